// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the register front end of a multi-channel event timer. A simple request bus carries reads and writes that are 4 or 8 bytes wide. The block decodes them into 64-bit registers: a global capability word, a global control register, a pending-interrupt register, the main counter window, and three registers per timer channel (setup, compare value and message route). A write of either width may land on either half of a 64-bit register. The block merges it into the stored value through a byte-lane mask, and fields that are fixed in hardware never change.

The counting, comparing and interrupt generation happen in neighbouring logic. This block only holds their register state and gives them single-cycle strobes. The strobes are: start and stop of the run, loading of a new counter value, and a write to a channel's compare value. The bus answers every request exactly one cycle after it is presented.

Top module: `evt_timer_regs`

## Requirements
- R1: Only accesses of 4 or 8 bytes (`req_size` = 4 or 8) are accepted. Any other size has no effect on any register, returns read data 0 and raises `rsp_err`.
- R2: An access whose address is not a multiple of its own size has no effect, returns read data 0 and raises `rsp_err`.
- R3: A 4-byte access at register offset +0 touches bits 31:0 and one at offset +4 touches bits 63:32 (write data taken from `req_wdata[31:0]`). A 4-byte read returns the selected half in `rsp_rdata[31:0]`, with the upper 32 bits zero. This applies to every register, including the per-channel route register at channel base + 0x10.
- R4: The capability word at 0x000 reads: bits 7:0 = 1, bits 12:8 = channel count minus one, bit 13 = 0 (32-bit counter), bit 15 = 1 (legacy routing capable), bits 31:16 = `VENDOR_ID`, bits 63:32 = `TICK_FS`. Writes to it have no effect.
- R5: The global control register at 0x010 stores bit 0 (run enable) and bit 1 (legacy routing). All its other bits read 0. Its bits drive `gen_enable` and `gen_legacy`.
- R6: A control write that changes run enable from 0 to 1 gives a one-cycle `run_start` pulse in the response cycle. A change from 1 to 0 gives a one-cycle `run_stop` pulse. The two pulses are never high together.
- R7: A write to the counter window at 0x0F0 zero-extends `cnt_value` to 64 bits, merges the write into it and pulses `cnt_load` with the low 32 bits on `cnt_load_val`. If run enable is set, the same cycle also pulses `run_start`. A read returns `cnt_value` zero-extended.
- R8: The channel setup register at 0x100 + 0x20·n keeps bits 63:32 (allowed route mask), bit 15 (message capable), bit 5 (wide counter capable) and bit 4 (periodic capable) at their stored values on every write. Bit 8 (force 32-bit) always reads 0. All other bits are writable.
- R9: After reset each setup register reads 0x0000_0000_0000_8010, each compare value reads 0xFFFF_FFFF and each route register reads 0. Control and pending registers read 0.
- R10: The pending register at 0x020 holds one bit per channel. A bit is set by `tmr_int_set` and cleared by writing 1 to it. A set and a clear of the same bit in one cycle leave it set.
- R11: Reads of unmapped offsets return 0 without `rsp_err`, and writes to them change nothing. This includes channel indices at or beyond the channel count and the unused slot at channel base + 0x18.
- R12: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high.
- R13: The compare value at channel base + 0x08 is 32 bits wide: writes to its upper half change nothing and its upper half reads 0. Any accepted write to it pulses that channel's bit of `tmr_cmp_wr` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the block |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Read data |
| rsp_err | output | 1 | Rejected size or alignment |
| cnt_value | input | 32 | Current main counter value |
| tmr_int_set | input | N_TIMERS | Per-channel pending set strobes |
| gen_enable | output | 1 | Run enable |
| gen_legacy | output | 1 | Legacy routing select |
| isr_bits | output | N_TIMERS | Pending bits |
| run_start | output | 1 | Start (or restart) pulse |
| run_stop | output | 1 | Stop pulse |
| cnt_load | output | 1 | Counter load pulse |
| cnt_load_val | output | 32 | Value to load |
| tmr_cfg | output | 64·N_TIMERS | Channel setup registers, channel 0 lowest |
| tmr_cmp | output | 32·N_TIMERS | Channel compare values |
| tmr_route | output | 64·N_TIMERS | Channel message route registers |
| tmr_cmp_wr | output | N_TIMERS | Compare write strobes |

## Verification
The bench builds the block with N_TIMERS = 5 and ADDR_W = 11. With five channels, the last channel sits at 0x180 and the first missing channel at 0x1A0, so random addresses up to 0x1BF reach every mapped register, the out-of-range channel slots and the unused per-channel slot. A small count also makes the capability count field (value 4) differ from the default build.

// File: rtl/evt_regs_pkg.sv
package evt_regs_pkg;

    typedef enum logic [2:0] {
        K_NONE, K_CAP, K_GCFG, K_ISR, K_CNT, K_TCFG, K_TCMP, K_TROUTE
    } reg_kind_e;

    typedef struct packed {
        logic      legal;
        reg_kind_e kind;
        logic [4:0] tidx;
        logic      hi;
        logic      wide;
    } dec_t;

    typedef struct packed {
        logic [63:0] data;
        logic [63:0] mask;
    } wpack_t;

    localparam int OFF_CAP   = 'h000;
    localparam int OFF_GCFG  = 'h010;
    localparam int OFF_ISR   = 'h020;
    localparam int OFF_CNT   = 'h0F0;
    localparam int OFF_TBASE = 'h100;

    localparam logic [63:0] TCFG_RO   = 64'hFFFF_FFFF_0000_8030;
    localparam logic [63:0] TCFG_F32  = 64'h0000_0000_0000_0100;
    localparam logic [63:0] TCFG_RST  = 64'h0000_0000_0000_8010;

    function automatic wpack_t place(input logic [63:0] wd, input logic wide, input logic hi);
        wpack_t p;
        if (wide) begin
            p.data = wd;
            p.mask = '1;
        end else if (hi) begin
            p.data = {wd[31:0], 32'h0};
            p.mask = {32'hFFFF_FFFF, 32'h0};
        end else begin
            p.data = {32'h0, wd[31:0]};
            p.mask = {32'h0, 32'hFFFF_FFFF};
        end
        return p;
    endfunction

    function automatic logic [63:0] merge64(input logic [63:0] old, input wpack_t p);
        return (old & ~p.mask) | (p.data & p.mask);
    endfunction

    function automatic logic [31:0] merge32(input logic [31:0] old, input wpack_t p);
        return (old & ~p.mask[31:0]) | (p.data[31:0] & p.mask[31:0]);
    endfunction

    function automatic logic [63:0] tcfg_next(input logic [63:0] old, input wpack_t p);
        logic [63:0] nv;
        nv = merge64(old, p);
        return (nv & ~(TCFG_RO | TCFG_F32)) | (old & TCFG_RO);
    endfunction

    function automatic logic [63:0] half_sel(input logic [63:0] v, input logic wide, input logic hi);
        if (wide) return v;
        return hi ? {32'h0, v[63:32]} : {32'h0, v[31:0]};
    endfunction

    function automatic logic [63:0] cap_word(input int n, input logic [15:0] vid, input logic [31:0] tick);
        logic [63:0] w;
        w        = '0;
        w[7:0]   = 8'd1;
        w[12:8]  = 5'(n - 1);
        w[15]    = 1'b1;
        w[31:16] = vid;
        w[63:32] = tick;
        return w;
    endfunction

endpackage

// File: rtl/evt_reg_decode.sv
module evt_reg_decode
    import evt_regs_pkg::*;
#(
    parameter int N_TIMERS = 8,
    parameter int ADDR_W   = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        size,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] TBASE = ADDR_W'(OFF_TBASE);

    logic              size_ok;
    logic              aligned;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] idx;

    always_comb begin
        size_ok  = (size == 4'd4) || (size == 4'd8);
        aligned  = (size == 4'd8) ? (addr[2:0] == 3'b000) : (addr[1:0] == 2'b00);
        base     = {addr[ADDR_W-1:3], 3'b000};
        off      = addr - TBASE;
        idx      = off >> 5;
        dec      = '0;
        dec.wide = (size == 4'd8);
        dec.hi   = addr[2];
        dec.legal = size_ok && aligned;
        dec.tidx = idx[4:0];
        dec.kind = K_NONE;
        if (dec.legal) begin
            if (base == ADDR_W'(OFF_CAP))       dec.kind = K_CAP;
            else if (base == ADDR_W'(OFF_GCFG)) dec.kind = K_GCFG;
            else if (base == ADDR_W'(OFF_ISR))  dec.kind = K_ISR;
            else if (base == ADDR_W'(OFF_CNT))  dec.kind = K_CNT;
            else if (addr >= TBASE && idx < ADDR_W'(N_TIMERS)) begin
                case (off[4:3])
                    2'd0:    dec.kind = K_TCFG;
                    2'd1:    dec.kind = K_TCMP;
                    2'd2:    dec.kind = K_TROUTE;
                    default: dec.kind = K_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/evt_timer_bank.sv
module evt_timer_bank
    import evt_regs_pkg::*;
#(
    parameter int N_TIMERS = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  dec_t                   dec,
    input  wpack_t                 wp,
    output logic [N_TIMERS*64-1:0] cfg_flat,
    output logic [N_TIMERS*32-1:0] cmp_flat,
    output logic [N_TIMERS*64-1:0] route_flat,
    output logic [N_TIMERS-1:0]    cmp_wr
);
    for (genvar i = 0; i < N_TIMERS; i++) begin : g_ch
        logic [63:0] cfg_q;
        logic [31:0] cmp_q;
        logic [63:0] route_q;
        logic        wr_pulse_q;
        logic        hit;

        assign hit = wr_en && (dec.tidx == 5'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q      <= TCFG_RST;
                cmp_q      <= '1;
                route_q    <= '0;
                wr_pulse_q <= 1'b0;
            end else begin
                wr_pulse_q <= hit && (dec.kind == K_TCMP);
                if (hit && dec.kind == K_TCFG)   cfg_q   <= tcfg_next(cfg_q, wp);
                if (hit && dec.kind == K_TCMP)   cmp_q   <= merge32(cmp_q, wp);
                if (hit && dec.kind == K_TROUTE) route_q <= merge64(route_q, wp);
            end
        end

        assign cfg_flat[i*64 +: 64]   = cfg_q;
        assign cmp_flat[i*32 +: 32]   = cmp_q;
        assign route_flat[i*64 +: 64] = route_q;
        assign cmp_wr[i]              = wr_pulse_q;
    end
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import evt_regs_pkg::*;
#(
    parameter int          N_TIMERS  = 8,
    parameter int          ADDR_W    = 11,
    parameter logic [15:0] VENDOR_ID = 16'hE7A1,
    parameter logic [31:0] TICK_FS   = 32'd100_000_000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [3:0]             req_size,
    input  logic [63:0]            req_wdata,
    output logic                   rsp_valid,
    output logic [63:0]            rsp_rdata,
    output logic                   rsp_err,
    input  logic [31:0]            cnt_value,
    input  logic [N_TIMERS-1:0]    tmr_int_set,
    output logic                   gen_enable,
    output logic                   gen_legacy,
    output logic [N_TIMERS-1:0]    isr_bits,
    output logic                   run_start,
    output logic                   run_stop,
    output logic                   cnt_load,
    output logic [31:0]            cnt_load_val,
    output logic [N_TIMERS*64-1:0] tmr_cfg,
    output logic [N_TIMERS*32-1:0] tmr_cmp,
    output logic [N_TIMERS*64-1:0] tmr_route,
    output logic [N_TIMERS-1:0]    tmr_cmp_wr
);
    localparam logic [63:0] CAP_VALUE = cap_word(N_TIMERS, VENDOR_ID, TICK_FS);

    if (N_TIMERS < 3 || N_TIMERS > 32) begin : g_bad_count
        $error("N_TIMERS must lie in 3..32");
    end

    dec_t          dec;
    wpack_t        wp;
    logic          wr_en;
    logic [1:0]    gcfg_q;
    logic [1:0]    gcfg_new;
    logic [N_TIMERS-1:0] isr_q;
    logic [N_TIMERS-1:0] isr_clr;
    logic [63:0]   full_rd;
    logic [63:0]   rd_val;
    int            sel;

    evt_reg_decode #(.N_TIMERS(N_TIMERS), .ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .size (req_size),
        .dec  (dec)
    );

    assign wp    = place(req_wdata, dec.wide, dec.hi);
    assign wr_en = req_valid && req_write && dec.legal;
    assign sel   = int'(dec.tidx);

    evt_timer_bank #(.N_TIMERS(N_TIMERS)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .dec        (dec),
        .wp         (wp),
        .cfg_flat   (tmr_cfg),
        .cmp_flat   (tmr_cmp),
        .route_flat (tmr_route),
        .cmp_wr     (tmr_cmp_wr)
    );

    always_comb begin
        gcfg_new = (gcfg_q & ~wp.mask[1:0]) | (wp.data[1:0] & wp.mask[1:0]);
        isr_clr  = (wr_en && dec.kind == K_ISR) ? (wp.data[N_TIMERS-1:0] & wp.mask[N_TIMERS-1:0]) : '0;
    end

    always_comb begin
        case (dec.kind)
            K_CAP:    full_rd = CAP_VALUE;
            K_GCFG:   full_rd = {62'h0, gcfg_q};
            K_ISR:    full_rd = 64'(isr_q);
            K_CNT:    full_rd = {32'h0, cnt_value};
            K_TCFG:   full_rd = tmr_cfg[sel*64 +: 64];
            K_TCMP:   full_rd = {32'h0, tmr_cmp[sel*32 +: 32]};
            K_TROUTE: full_rd = tmr_route[sel*64 +: 64];
            default:  full_rd = '0;
        endcase
        rd_val = half_sel(full_rd, dec.wide, dec.hi);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gcfg_q       <= '0;
            isr_q        <= '0;
            run_start    <= 1'b0;
            run_stop     <= 1'b0;
            cnt_load     <= 1'b0;
            cnt_load_val <= '0;
            rsp_valid    <= 1'b0;
            rsp_err      <= 1'b0;
            rsp_rdata    <= '0;
        end else begin
            run_start <= 1'b0;
            run_stop  <= 1'b0;
            cnt_load  <= 1'b0;
            isr_q     <= (isr_q & ~isr_clr) | tmr_int_set;
            if (wr_en && dec.kind == K_GCFG) begin
                gcfg_q    <= gcfg_new;
                run_start <= !gcfg_q[0] && gcfg_new[0];
                run_stop  <= gcfg_q[0] && !gcfg_new[0];
            end
            if (wr_en && dec.kind == K_CNT) begin
                cnt_load     <= 1'b1;
                cnt_load_val <= merge32(cnt_value, wp);
                run_start    <= gcfg_q[0];
            end
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !dec.legal;
            rsp_rdata <= (req_valid && !req_write) ? rd_val : '0;
        end
    end

    assign gen_enable = gcfg_q[0];
    assign gen_legacy = gcfg_q[1];
    assign isr_bits   = isr_q;
endmodule

// File: rtl/evt_timer_regs_chk.sv
module evt_timer_regs_chk #(
    parameter int N_TIMERS = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   req_valid,
    input logic                   rsp_valid,
    input logic                   rsp_err,
    input logic [63:0]            rsp_rdata,
    input logic                   gen_enable,
    input logic                   run_start,
    input logic                   run_stop,
    input logic [N_TIMERS*64-1:0] tmr_cfg,
    input logic [N_TIMERS-1:0]    tmr_cmp_wr
);
    assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    assert_rsp_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    assert_err_zero_R1: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_rdata == 64'h0));
    assert_pulse_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(run_start && run_stop));
    assert_stop_edge_R6: assert property (@(posedge clk) disable iff (rst)
        run_stop |-> (!gen_enable && $past(gen_enable)));
    assert_start_edge_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(gen_enable) |-> run_start);
    assert_cmp_strobe_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tmr_cmp_wr));

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_ch
        assert_fixed_fields_R8: assert property (@(posedge clk) disable iff (rst)
            (tmr_cfg[i*64+8] == 1'b0) && (tmr_cfg[i*64+15] == 1'b1) &&
            (tmr_cfg[i*64+4] == 1'b1) && (tmr_cfg[i*64+5] == 1'b0) &&
            (tmr_cfg[i*64+32 +: 32] == 32'h0));
    end
endmodule

bind evt_timer_regs evt_timer_regs_chk #(.N_TIMERS(N_TIMERS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .gen_enable (gen_enable),
    .run_start  (run_start),
    .run_stop   (run_stop),
    .tmr_cfg    (tmr_cfg),
    .tmr_cmp_wr (tmr_cmp_wr)
);

// File: tb/evt_timer_regs_bench.sv
module evt_timer_regs_bench;
    localparam int          N   = 5;
    localparam int          AW  = 11;
    localparam logic [15:0] VID = 16'hE7A1;
    localparam logic [31:0] TFS = 32'd100_000_000;
    localparam logic [63:0] RO_M  = 64'hFFFF_FFFF_0000_8030;
    localparam logic [63:0] F32_M = 64'h100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0] req_size = '0;
    logic [63:0] req_wdata = '0;
    logic rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    logic [31:0] cnt_in = 32'h1234_5678;
    logic [N-1:0] int_set = '0;
    logic gen_enable, gen_legacy, run_start, run_stop, cnt_load;
    logic [N-1:0] isr_bits, cmp_wr;
    logic [31:0] cnt_load_val;
    logic [N*64-1:0] tcfg, troute;
    logic [N*32-1:0] tcmp;

    always #4 clk = ~clk;

    evt_timer_regs #(.N_TIMERS(N), .ADDR_W(AW), .VENDOR_ID(VID), .TICK_FS(TFS)) u_evt_timer_regs (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .cnt_value(cnt_in), .tmr_int_set(int_set), .gen_enable(gen_enable),
        .gen_legacy(gen_legacy), .isr_bits(isr_bits), .run_start(run_start),
        .run_stop(run_stop), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
        .tmr_cfg(tcfg), .tmr_cmp(tcmp), .tmr_route(troute), .tmr_cmp_wr(cmp_wr)
    );

    int n_cmp = 0, n_bad = 0;

    // bench model
    bit          m_en = 0, m_leg = 0;
    logic [N-1:0] m_isr = '0;
    logic [63:0] m_cfg [N];
    logic [31:0] m_cmp [N];
    logic [63:0] m_route [N];

    task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    function automatic bit b_legal(input int a, input int sz);
        return (sz == 4 || sz == 8) && (a % sz == 0);
    endfunction

    // 0 none,1 cap,2 ctrl,3 pending,4 counter,5 setup,6 compare,7 route
    function automatic int b_region(input int a, output int ti);
        int b = a - (a % 8);
        ti = 0;
        if (b == 'h000) return 1;
        if (b == 'h010) return 2;
        if (b == 'h020) return 3;
        if (b == 'h0F0) return 4;
        if (a >= 'h100 && (a - 'h100) / 32 < N) begin
            ti = (a - 'h100) / 32;
            case (((a - 'h100) % 32) / 8)
                0: return 5;
                1: return 6;
                2: return 7;
                default: return 0;
            endcase
        end
        return 0;
    endfunction

    function automatic logic [63:0] b_cap();
        return {TFS, VID, 1'b1, 1'b0, 1'b0, 5'(N - 1), 8'h01};
    endfunction

    function automatic logic [63:0] b_full(input int rg, input int ti);
        case (rg)
            1: return b_cap();
            2: return {62'h0, m_leg, m_en};
            3: return 64'(m_isr);
            4: return {32'h0, cnt_in};
            5: return m_cfg[ti];
            6: return {32'h0, m_cmp[ti]};
            7: return m_route[ti];
            default: return 64'h0;
        endcase
    endfunction

    function automatic string b_tag(input int a, input int sz);
        int ti, rg;
        if (!(sz == 4 || sz == 8)) return "R1";
        if (!b_legal(a, sz)) return "R2";
        rg = b_region(a, ti);
        case (rg)
            1: return "R4";  2: return "R5";  3: return "R10"; 4: return "R7";
            5: return "R8";  6: return "R13"; 7: return "R3";
            default: return "R11";
        endcase
    endfunction

    task automatic acc(input bit wr, input int a, input int sz, input logic [63:0] wd,
                       input logic [N-1:0] setm, input string tag_in);
        string tag;
        int ti, rg;
        bit lg, hi;
        logic [63:0] full, exp_rd, d, m, nv;
        logic [31:0] exp_lv;
        bit e_start, e_stop, e_load;
        logic [N-1:0] e_cw;
        tag = (tag_in == "") ? b_tag(a, sz) : tag_in;
        lg = b_legal(a, sz);
        rg = b_region(a, ti);
        hi = ((a / 4) % 2) == 1;
        full = b_full(rg, ti);
        exp_rd = 64'h0;
        if (lg && !wr) exp_rd = (sz == 8) ? full : (hi ? {32'h0, full[63:32]} : {32'h0, full[31:0]});
        if (sz == 8) begin d = wd; m = '1; end
        else if (hi) begin d = {wd[31:0], 32'h0}; m = {32'hFFFF_FFFF, 32'h0}; end
        else begin d = {32'h0, wd[31:0]}; m = {32'h0, 32'hFFFF_FFFF}; end
        e_start = 0; e_stop = 0; e_load = 0; e_cw = '0; exp_lv = 'x;
        if (wr && lg) begin
            nv = (full & ~m) | (d & m);
            case (rg)
                2: begin
                    e_start = !m_en && nv[0];
                    e_stop  = m_en && !nv[0];
                    m_en = nv[0]; m_leg = nv[1];
                end
                3: m_isr = m_isr & ~nv[N-1:0] & ~m_isr | (m_isr & ~(d[N-1:0] & m[N-1:0]));
                4: begin e_load = 1; exp_lv = nv[31:0]; e_start = m_en; end
                5: m_cfg[ti] = (nv & ~(RO_M | F32_M)) | (m_cfg[ti] & RO_M);
                6: begin m_cmp[ti] = nv[31:0]; e_cw[ti] = 1'b1; end
                7: m_route[ti] = nv;
                default: ;
            endcase
        end
        m_isr = m_isr | setm;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = AW'(a); req_size = 4'(sz);
        req_wdata = wd; int_set = setm;
        @(posedge clk);
        #1;
        chk("R12", "rsp_valid", 64'(rsp_valid), 64'(1));
        chk(tag, "rsp_err", 64'(rsp_err), 64'(!lg));
        chk(tag, "rsp_rdata", rsp_rdata, exp_rd);
        chk(tag, "cnt_load", 64'(cnt_load), 64'(e_load));
        if (e_load) chk(tag, "cnt_load_val", 64'(cnt_load_val), 64'(exp_lv));
        chk(tag, "run_start", 64'(run_start), 64'(e_start));
        chk(tag, "run_stop", 64'(run_stop), 64'(e_stop));
        chk(tag, "cmp_wr", 64'(cmp_wr), 64'(e_cw));
        req_valid = 0; int_set = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_cfg[i] = 64'h8010; m_cmp[i] = 32'hFFFF_FFFF; m_route[i] = '0;
        end
        void'($urandom(32'd5150));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // reset state, R9
        chk("R9", "gen_enable", 64'(gen_enable), 0);
        chk("R9", "isr_bits", 64'(isr_bits), 0);
        chk("R9", "tmr_cmp[0]", 64'(tcmp[31:0]), 64'hFFFF_FFFF);
        chk("R9", "tmr_cfg[4]", tcfg[4*64 +: 64], 64'h8010);
        chk("R9", "tmr_route[2]", troute[2*64 +: 64], 0);
        acc(0, 'h108, 8, 0, 0, "R9");
        // R4 capability
        acc(0, 'h000, 8, 0, 0, "R4");
        acc(0, 'h004, 4, 0, 0, "R3");
        acc(1, 'h000, 8, '1, 0, "R4");
        acc(0, 'h000, 8, 0, 0, "R4");
        // R1 bad widths
        acc(0, 'h000, 2, 0, 0, "R1");
        acc(1, 'h010, 1, 64'h1, 0, "R1");
        chk("R1", "gen_enable after byte write", 64'(gen_enable), 0);
        // R2 misaligned
        acc(1, 'h014, 8, '1, 0, "R2");
        acc(1, 'h122, 4, '1, 0, "R2");
        acc(0, 'h120, 8, 0, 0, "R2");
        // R5 / R6 control
        acc(1, 'h010, 8, '1, 0, "R6");
        acc(0, 'h010, 8, 0, 0, "R5");
        chk("R5", "gen_legacy", 64'(gen_legacy), 1);
        acc(1, 'h010, 4, 64'h1, 0, "R6");
        acc(1, 'h010, 4, 64'h0, 0, "R6");
        acc(1, 'h010, 4, 64'h1, 0, "R6");
        // R7 counter window
        acc(1, 'h0F0, 4, 64'hAABB_CCDD, 0, "R7");
        acc(1, 'h0F4, 4, 64'h9999_9999, 0, "R7");
        acc(0, 'h0F0, 8, 0, 0, "R7");
        // R8 setup fixed fields
        acc(1, 'h120, 8, '1, 0, "R8");
        acc(0, 'h120, 8, 0, 0, "R8");
        acc(1, 'h124, 4, 64'h0, 0, "R8");
        acc(0, 'h124, 4, 0, 0, "R8");
        // R13 compare
        acc(1, 'h12C, 4, 64'h1111_2222, 0, "R13");
        acc(0, 'h128, 8, 0, 0, "R13");
        acc(1, 'h128, 4, 64'h0000_0400, 0, "R13");
        acc(0, 'h128, 8, 0, 0, "R13");
        chk("R13", "tmr_cmp[1] port", 64'(tcmp[32 +: 32]), 64'h400);
        // R3 route halves
        acc(1, 'h194, 4, 64'hDEAD_BEEF, 0, "R3");
        acc(1, 'h190, 4, 64'h0BAD_F00D, 0, "R3");
        acc(0, 'h190, 8, 0, 0, "R3");
        // R10 pending
        acc(0, 'h020, 8, 0, 5'b10101, "R10");
        acc(0, 'h020, 8, 0, 0, "R10");
        acc(1, 'h020, 4, 64'h5, 5'b00001, "R10");
        acc(0, 'h020, 4, 0, 0, "R10");
        chk("R10", "isr_bits port", 64'(isr_bits), 64'b10001);
        // R11 unmapped
        acc(1, 'h1A0, 8, '1, 0, "R11");
        acc(0, 'h1A0, 8, 0, 0, "R11");
        acc(1, 'h118, 8, '1, 0, "R11");
        acc(0, 'h118, 8, 0, 0, "R11");
        acc(0, 'h040, 4, 0, 0, "R11");
        // R12 idle
        @(negedge clk); @(posedge clk); #1;
        chk("R12", "rsp_valid idle", 64'(rsp_valid), 0);
        // constrained random
        cnt_in = 32'h0F0F_0001;
        for (int k = 0; k < 800; k++) begin
            int a, sz;
            int szl[8] = '{4, 8, 8, 4, 1, 2, 3, 4};
            int fix[8] = '{'h000, 'h004, 'h010, 'h014, 'h020, 'h024, 'h0F0, 'h0F4};
            logic [N-1:0] sm;
            if ($urandom % 4 == 0) a = fix[$urandom % 8];
            else a = int'($urandom % 'h1C0);
            if ($urandom % 5 != 0) a = a - (a % 4);
            sz = szl[$urandom % 8];
            sm = ($urandom % 6 == 0) ? N'($urandom) : '0;
            acc($urandom % 2 == 1, a, sz, {$urandom, $urandom}, sm, "");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule